// File: doc/BRIEF.md
# Random-Word Generator Command/Status Port

This block puts a 32-bit register port in front of a pseudo-random word engine. The host controls it only by writing magic command words to one control location. It learns about progress by reading a byte-coded status location, and it collects each fresh word from a data location. The control register and the data register share offset 0. Writes there go to control and reads there return data. Status sits at offset 4.

A sequencer inside the block walks through a fixed bring-up order:

1. The reset command starts a reset countdown and returns an acknowledgement code.
2. The release and enable commands arm the engine.
3. The zeroize command wipes the word register and the entropy state, then runs a timed startup self-test. It reports a pass or fail code.
4. Acknowledging a pass starts word generation.

After each word the host reads the data, writes the read-acknowledge command, and then writes enable to request the next word. The entropy source is a stand-in 32-bit Galois LFSR. A test input forces the self-test to report failure.

Top module: `rng_csr_wrap`

## Requirements
- R1: A write to byte offset 0 is a command and writes anywhere else are discarded. A read at offset 0 returns the word register and a read at offset 4 returns the 8-bit status code zero-extended. A read at any other offset returns 0. Read data appears on the clock edge that samples the read strobe and reflects the state before that edge.
- R2: The command 0x00000001 is accepted in every state. Status reads 0x00 while the countdown runs, and the state becomes reset-acknowledged (status 0xAC) RST_CYC cycles after the edge that took the write.
- R3: Command 0x00000002 moves the reset-acknowledged state to idle. Command 0x80000000 moves idle to armed. Both idle and armed report status 0x00.
- R4: Command 0x80000004 is accepted in armed and every later state (self-test, pass, fail, generating, word ready, word consumed). On the accepting edge it clears the word register and the LFSR to 0. Status reads 0x00 during the self-test, which ends ST_CYC cycles after that edge.
- R5: When the self-test ends, status becomes 0x57 if the fail hook is low at that edge and 0xFA if it is high. At that edge the LFSR is loaded with SEED.
- R6: Command 0x80000008 in the pass state starts generation. In the fail state it is ignored and status stays 0xFA.
- R7: During generation the LFSR advances once per cycle for GEN_CYC cycles, with the step s' = (s<<1) ^ (s[31] ? 0x00400007 : 0). The word register takes the value after the last step, and status then reads 0xED.
- R8: Command 0x8000000F in the word-ready state moves to consumed (status 0x00). A following 0x80000000 starts generation of the next word, which continues the same LFSR sequence.
- R9: A write of any other word is ignored, and so is a listed command sent in a state that does not accept it. Both leave the state, the status and the word register unchanged.
- R10: Reading the word register when no fresh word is ready returns the last word and changes no state.
- R11: The synchronous active-high reset returns the block to idle, with status 0x00, the word register 0 and the read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data (command word) |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| tst_force_fail | input | 1 | Test hook: forces the self-test to fail |

## Verification
A command takes effect on the edge that samples its write. A read returns the state as it stood before its own edge. So a status change that is due N cycles after a command shows first on a read issued N+1 cycles after the command write. The reset code is due RST_CYC cycles after the write, the self-test result ST_CYC cycles after it, and a new word GEN_CYC cycles after it. The bench runs these in order: single-cycle bus operations, interleaved with exact idle counts. It reads status once on the last cycle before each result is due and once on the first cycle after. An early or late transition therefore fails a check. Expected words come from the stated LFSR step, applied GEN_CYC times per word to SEED.

// File: rtl/rng_csr_pkg.sv
package rng_csr_pkg;

  localparam int WORD_W = 32;

  localparam logic [WORD_W-1:0] CMD_RESET   = 32'h0000_0001;
  localparam logic [WORD_W-1:0] CMD_RELEASE = 32'h0000_0002;
  localparam logic [WORD_W-1:0] CMD_ENABLE  = 32'h8000_0000;
  localparam logic [WORD_W-1:0] CMD_ZERO    = 32'h8000_0004;
  localparam logic [WORD_W-1:0] CMD_ACK_Z   = 32'h8000_0008;
  localparam logic [WORD_W-1:0] CMD_ACK_RD  = 32'h8000_000F;

  localparam logic [7:0] STS_NONE   = 8'h00;
  localparam logic [7:0] STS_RSTACK = 8'hAC;
  localparam logic [7:0] STS_PASS   = 8'h57;
  localparam logic [7:0] STS_FAIL   = 8'hFA;
  localparam logic [7:0] STS_WORD   = 8'hED;

  typedef enum logic [3:0] {
    S_IDLE, S_RST_WAIT, S_RST_ACK, S_ARMED, S_SELFTEST,
    S_ST_PASS, S_ST_FAIL, S_GEN, S_READY, S_CONSUMED
  } seq_state_t;

  function automatic logic [7:0] status_of(seq_state_t s);
    case (s)
      S_RST_ACK: return STS_RSTACK;
      S_ST_PASS: return STS_PASS;
      S_ST_FAIL: return STS_FAIL;
      S_READY:   return STS_WORD;
      default:   return STS_NONE;
    endcase
  endfunction

  function automatic logic is_known(logic [WORD_W-1:0] w);
    return (w == CMD_RESET) || (w == CMD_RELEASE) || (w == CMD_ENABLE) ||
           (w == CMD_ZERO) || (w == CMD_ACK_Z) || (w == CMD_ACK_RD);
  endfunction

endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] TAPS = 32'h0040_0007,
  parameter logic [W-1:0] SEED = 32'hACE1_2468
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] state_q,
  output logic [W-1:0] next_val
);

  always_comb begin
    next_val = {state_q[W-2:0], 1'b0} ^ (state_q[W-1] ? TAPS : '0);
  end

  // clear beats load beats step
  always_ff @(posedge clk) begin
    if (rst || clr)  state_q <= '0;
    else if (load)   state_q <= SEED;
    else if (step)   state_q <= next_val;
  end

endmodule

// File: rtl/rng_seq_fsm.sv
module rng_seq_fsm
  import rng_csr_pkg::*;
#(
  parameter int RST_CYC = 4000,
  parameter int ST_CYC  = 500000,
  parameter int GEN_CYC = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_vld,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              fail_hook,
  output seq_state_t        state_q,
  output logic              ent_clr,
  output logic              ent_load,
  output logic              ent_step,
  output logic              word_cap
);

  localparam int MAX_A = (RST_CYC > ST_CYC) ? RST_CYC : ST_CYC;
  localparam int MAX_C = (MAX_A > GEN_CYC) ? MAX_A : GEN_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  localparam logic [CNT_W-1:0] RST_LD = CNT_W'(RST_CYC - 1);
  localparam logic [CNT_W-1:0] ST_LD  = CNT_W'(ST_CYC - 1);
  localparam logic [CNT_W-1:0] GEN_LD = CNT_W'(GEN_CYC - 1);

  seq_state_t       nxt;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             acc;

  always_comb begin
    nxt      = state_q;
    cnt_n    = cnt_q;
    ent_clr  = 1'b0;
    ent_load = 1'b0;
    ent_step = 1'b0;
    word_cap = 1'b0;
    acc      = 1'b0;

    // timed phases
    case (state_q)
      S_RST_WAIT: begin
        if (cnt_q == '0) nxt = S_RST_ACK;
        else             cnt_n = cnt_q - 1'b1;
      end
      S_SELFTEST: begin
        if (cnt_q == '0) begin
          nxt      = fail_hook ? S_ST_FAIL : S_ST_PASS;
          ent_load = 1'b1;
        end else cnt_n = cnt_q - 1'b1;
      end
      S_GEN: begin
        ent_step = 1'b1;
        if (cnt_q == '0) begin
          nxt      = S_READY;
          word_cap = 1'b1;
        end else cnt_n = cnt_q - 1'b1;
      end
      default: ;
    endcase

    // an accepted command overrides the timed phase
    if (cmd_vld) begin
      case (cmd_word)
        CMD_RESET: begin
          acc = 1'b1; nxt = S_RST_WAIT; cnt_n = RST_LD;
        end
        CMD_RELEASE: if (state_q == S_RST_ACK) begin
          acc = 1'b1; nxt = S_IDLE;
        end
        CMD_ENABLE: begin
          if (state_q == S_IDLE) begin
            acc = 1'b1; nxt = S_ARMED;
          end else if (state_q == S_CONSUMED) begin
            acc = 1'b1; nxt = S_GEN; cnt_n = GEN_LD;
          end
        end
        CMD_ZERO: if (!(state_q inside {S_IDLE, S_RST_WAIT, S_RST_ACK})) begin
          acc = 1'b1; nxt = S_SELFTEST; cnt_n = ST_LD; ent_clr = 1'b1;
        end
        CMD_ACK_Z: if (state_q == S_ST_PASS) begin
          acc = 1'b1; nxt = S_GEN; cnt_n = GEN_LD;
        end
        CMD_ACK_RD: if (state_q == S_READY) begin
          acc = 1'b1; nxt = S_CONSUMED;
        end
        default: ;
      endcase
      if (acc) begin
        ent_load = 1'b0;
        ent_step = 1'b0;
        word_cap = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= nxt;
      cnt_q   <= cnt_n;
    end
  end

  // R2: acknowledgement is only reached by finishing the countdown
  p_ack_after_wait_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_RST_ACK && $past(state_q) != S_RST_ACK) |-> $past(state_q) == S_RST_WAIT);

  // R9: unknown words leave a waiting state untouched
  p_unknown_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && !is_known(cmd_word) &&
     (state_q inside {S_IDLE, S_RST_ACK, S_ARMED, S_ST_PASS, S_ST_FAIL, S_READY, S_CONSUMED}))
    |=> state_q == $past(state_q));

  // R6: the fail state is only left by reset or zeroize
  p_fail_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_ST_FAIL && !(cmd_vld && (cmd_word == CMD_RESET || cmd_word == CMD_ZERO)))
    |=> state_q == S_ST_FAIL);

endmodule

// File: rtl/rng_csr_wrap.sv
module rng_csr_wrap
  import rng_csr_pkg::*;
#(
  parameter int          ADDR_W  = 4,
  parameter int          RST_CYC = 4000,
  parameter int          ST_CYC  = 500000,
  parameter int          GEN_CYC = 32,
  parameter logic [31:0] SEED    = 32'hACE1_2468
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic              tst_force_fail
);

  localparam logic [ADDR_W-1:0] OFS_CTRL_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_STATUS    = ADDR_W'(4);
  localparam logic [31:0]       LFSR_TAPS     = 32'h0040_0007;

  seq_state_t         st;
  logic               ent_clr, ent_load, ent_step, word_cap;
  logic [WORD_W-1:0]  lfsr_q, lfsr_nxt, word_q;
  logic               cmd_vld;

  assign cmd_vld = bus_wr && (bus_addr == OFS_CTRL_DATA);

  rng_seq_fsm #(
    .RST_CYC (RST_CYC),
    .ST_CYC  (ST_CYC),
    .GEN_CYC (GEN_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cmd_vld   (cmd_vld),
    .cmd_word  (bus_wdata),
    .fail_hook (tst_force_fail),
    .state_q   (st),
    .ent_clr   (ent_clr),
    .ent_load  (ent_load),
    .ent_step  (ent_step),
    .word_cap  (word_cap)
  );

  rng_lfsr #(
    .W    (WORD_W),
    .TAPS (LFSR_TAPS),
    .SEED (SEED)
  ) u_lfsr (
    .clk      (clk),
    .rst      (rst),
    .clr      (ent_clr),
    .load     (ent_load),
    .step     (ent_step),
    .state_q  (lfsr_q),
    .next_val (lfsr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst || ent_clr) word_q <= '0;
    else if (word_cap)  word_q <= lfsr_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        OFS_CTRL_DATA: bus_rdata <= word_q;
        OFS_STATUS:    bus_rdata <= {24'h0, status_of(st)};
        default:       bus_rdata <= '0;
      endcase
    end
  end

  // R4: zeroize wipes both word and entropy state
  p_zero_clear_r4: assert property (@(posedge clk) disable iff (rst)
    ent_clr |=> (word_q == '0) && (lfsr_q == '0));

  // R10: a consumed word stays put until a command arrives
  p_word_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (st == S_CONSUMED && !bus_wr) |=> $stable(word_q));

  // R1: status reads carry only the low byte
  p_status_byte_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFS_STATUS) |=> bus_rdata[31:8] == 24'h0);

  // R7: a word is ready only after generation
  p_ready_from_gen_r7: assert property (@(posedge clk) disable iff (rst)
    (st == S_READY && $past(st) != S_READY) |-> $past(st) == S_GEN);

endmodule

// File: tb/rng_csr_wrap_bench.sv
module rng_csr_wrap_bench;
  import rng_csr_pkg::*;

  localparam int          AW   = 4;
  localparam int          RSTC = 4;
  localparam int          STC  = 6;
  localparam int          GENC = 3;
  localparam logic [31:0] SD   = 32'h1234_5678;

  function automatic logic [31:0] adv(logic [31:0] s, int n);
    logic [31:0] v;
    v = s;
    for (int i = 0; i < n; i++) v = {v[30:0], 1'b0} ^ (v[31] ? 32'h0040_0007 : 32'h0);
    return v;
  endfunction

  localparam logic [31:0] W1 = adv(SD, GENC);
  localparam logic [31:0] W2 = adv(SD, 2 * GENC);

  // op: 0 write, 1 read-check, 2 idle(data cycles), 3 fail hook(data[0])
  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 45;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 4'h4, 32'h0,          32'h00,  8'd11}, // R11 status after reset
    '{2'd1, 4'h0, 32'h0,          32'h0,   8'd11}, // R11 word after reset
    '{2'd0, 4'h0, 32'h1234_5678,  32'h0,   8'd9},  // R9 bogus word
    '{2'd1, 4'h4, 32'h0,          32'h00,  8'd9},
    '{2'd0, 4'h0, CMD_RESET,      32'h0,   8'd2},  // R2
    '{2'd2, 4'h0, 32'd2,          32'h0,   8'd2},
    '{2'd1, 4'h4, 32'h0,          32'h00,  8'd2},
    '{2'd1, 4'h4, 32'h0,          32'h00,  8'd2},  // R2 last cycle before due
    '{2'd1, 4'h4, 32'h0,          32'hAC,  8'd2},
    '{2'd0, 4'h0, CMD_ZERO,       32'h0,   8'd9},  // R9 listed cmd, wrong state
    '{2'd1, 4'h4, 32'h0,          32'hAC,  8'd9},
    '{2'd0, 4'h0, CMD_RELEASE,    32'h0,   8'd3},  // R3
    '{2'd1, 4'h4, 32'h0,          32'h00,  8'd3},
    '{2'd0, 4'h0, CMD_ENABLE,     32'h0,   8'd3},
    '{2'd1, 4'h4, 32'h0,          32'h00,  8'd3},
    '{2'd0, 4'h0, CMD_ZERO,       32'h0,   8'd4},  // R4
    '{2'd1, 4'h0, 32'h0,          32'h0,   8'd4},
    '{2'd2, 4'h0, 32'd4,          32'h0,   8'd4},
    '{2'd1, 4'h4, 32'h0,          32'h00,  8'd4},  // R4 self-test still running
    '{2'd1, 4'h4, 32'h0,          32'h57,  8'd5},  // R5 pass
    '{2'd0, 4'h0, CMD_ACK_Z,      32'h0,   8'd6},  // R6
    '{2'd1, 4'h4, 32'h0,          32'h00,  8'd7},  // R7
    '{2'd2, 4'h0, 32'd1,          32'h0,   8'd7},
    '{2'd1, 4'h4, 32'h0,          32'h00,  8'd7},
    '{2'd1, 4'h4, 32'h0,          32'hED,  8'd7},
    '{2'd1, 4'h0, 32'h0,          W1,      8'd7},
    '{2'd0, 4'h0, 32'h8000_000C,  32'h0,   8'd9},  // R9 near-miss code
    '{2'd1, 4'h4, 32'h0,          32'hED,  8'd9},
    '{2'd0, 4'h0, CMD_ACK_RD,     32'h0,   8'd8},  // R8
    '{2'd1, 4'h4, 32'h0,          32'h00,  8'd8},
    '{2'd1, 4'h0, 32'h0,          W1,      8'd10}, // R10 stale word
    '{2'd1, 4'h4, 32'h0,          32'h00,  8'd10},
    '{2'd0, 4'h0, CMD_ENABLE,     32'h0,   8'd8},
    '{2'd2, 4'h0, 32'd3,          32'h0,   8'd8},
    '{2'd1, 4'h4, 32'h0,          32'hED,  8'd8},
    '{2'd1, 4'h0, 32'h0,          W2,      8'd8},
    '{2'd3, 4'h0, 32'h1,          32'h0,   8'd5},
    '{2'd0, 4'h0, CMD_ZERO,       32'h0,   8'd4},  // R4 from word-ready
    '{2'd1, 4'h0, 32'h0,          32'h0,   8'd4},
    '{2'd2, 4'h0, 32'd4,          32'h0,   8'd5},
    '{2'd1, 4'h4, 32'h0,          32'h00,  8'd5},
    '{2'd1, 4'h4, 32'h0,          32'hFA,  8'd5},  // R5 forced fail
    '{2'd0, 4'h0, CMD_ACK_Z,      32'h0,   8'd6},  // R6 ignored in fail
    '{2'd1, 4'h4, 32'h0,          32'hFA,  8'd6},
    '{2'd1, 4'h8, 32'h0,          32'h0,   8'd1}   // R1 unmapped offset
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic          tst_force_fail = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  rng_csr_wrap #(
    .ADDR_W (AW), .RST_CYC (RSTC), .ST_CYC (STC), .GEN_CYC (GENC), .SEED (SD)
  ) u_rng_csr_wrap (
    .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_wr (bus_wr),
    .bus_wdata (bus_wdata), .bus_rd (bus_rd), .bus_rdata (bus_rdata),
    .tst_force_fail (tst_force_fail)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below 5000", cyc);
      finish_run();
    end
  end

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_check(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    n_chk++;
    if (bus_rdata !== e) begin
      n_bad++;
      $display("FAIL %s: addr %0h actual %08h expected %08h", tag, a, bus_rdata, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      case (TBL[i].op)
        2'd0: bus_write(TBL[i].addr, TBL[i].data);
        2'd1: bus_check(TBL[i].addr, TBL[i].exp, $sformatf("R%0d row %0d", TBL[i].req, i));
        2'd2: repeat (int'(TBL[i].data)) @(negedge clk);
        default: tst_force_fail = TBL[i].data[0];
      endcase
    end
    tst_force_fail = 1'b0;

    // R11: synchronous reset from the fail state
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    n_chk++;
    if (bus_rdata !== 32'h0) begin
      n_bad++;
      $display("FAIL R11 read data: actual %08h expected 00000000", bus_rdata);
    end
    bus_check(4'h4, 32'h00, "R11 status");
    bus_check(4'h0, 32'h0,  "R11 word");

    // R1: a reset command at the status offset is discarded
    bus_write(4'h4, CMD_RESET);
    repeat (RSTC + 1) @(negedge clk);
    bus_check(4'h4, 32'h00, "R1 write off offset 0");

    // R2: reset accepted from idle again reaches the ack code
    bus_write(4'h0, CMD_RESET);
    repeat (RSTC) @(negedge clk);
    bus_check(4'h4, 32'hAC, "R2 reset from idle");

    finish_run();
  end

endmodule